// File: doc/BRIEF.md
# Phase Slope Limiter

This block sits in the error path of a digital PLL, between the phase detector and the loop filter. On every update tick, nominally every 125 µs, it receives one signed phase-error word in nanoseconds. It returns one bounded error word, so that the loop can never move the output phase by more than 5 ns in one tick. Any error beyond that bound is dropped, not saved for later ticks. An error far larger than the bound therefore becomes a slow, steady phase slew instead of a step.

Two controls change this behaviour. The fast-lock input, which is a submode of normal operation, bypasses the bound so the loop can pull in quickly. The mode input marks freerun or holdover. In those modes the measured error means nothing, so the block returns zero for every tick and ignores both the error word and fast-lock. Each tick is carried by a ready/valid transfer on the input. The result leaves through a registered ready/valid output one clock later.

Top module: `phase_slope_limiter`

## Requirements
- R1: While reset is held and right after it is released, `outValid` is 0, `outErr` is 0 and `inReady` is 1.
- R2: In normal mode (`opMode` = 2'b00) with `fastLock` low, an error inside the range -5..+5 (inclusive) is returned unchanged.
- R3: In normal mode with `fastLock` low, an error greater than +5 is returned as +5. This includes +32767.
- R4: In normal mode with `fastLock` low, an error less than -5 is returned as -5. This includes -32768.
- R5: In normal mode with `fastLock` high, the error is returned unchanged whatever its size.
- R6: In freerun (`opMode` = 2'b01) or holdover (`opMode` = 2'b10), the returned word is 0 whatever the error and `fastLock` are.
- R7: An input word is accepted on a clock edge where `inValid` and `inReady` are both 1. Exactly one output word with `outValid` = 1 appears after that same edge, and it leaves on the first edge with `outReady` = 1.
- R8: While `outValid` = 1 and `outReady` = 0, `inReady` is 0, `outValid` stays 1, `outErr` holds its value, and an offered input is not taken.
- R9: Excess error that was clamped in one tick has no effect on any later tick. Each result depends only on the word accepted for that tick.
- R10: The unused mode code `opMode` = 2'b11 behaves as holdover and returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | An error word is offered for this tick |
| inReady | output | 1 | The block can take an error word |
| inErr | input | 16 | Signed phase error in ns, two's complement |
| fastLock | input | 1 | Bypass the slope bound in normal mode |
| opMode | input | 2 | 00 normal, 01 freerun, 10 holdover, 11 treated as holdover |
| outValid | output | 1 | A limited word is available |
| outReady | input | 1 | The loop filter takes the limited word |
| outErr | output | 16 | Signed limited phase error in ns |

## Verification
Every result is due one clock after the edge that accepts its input, because only the output register lies on the path. The bench drives inputs on the falling edge and samples the result on the next falling edge, after exactly one rising edge. One falling edge later it checks that `outValid` has dropped, which confirms that one tick produced one word. Under backpressure the bench holds `outReady` low for several cycles. It checks on each falling edge that the word and `inReady` are unchanged. It then releases `outReady` and expects the pending input's result one edge later.

// File: rtl/psl_pkg.sv
package psl_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'b00,
    MODE_FREERUN  = 2'b01,
    MODE_HOLDOVER = 2'b10,
    MODE_SPARE    = 2'b11
  } op_mode_e;

  // Strobes from control to datapath for one accepted tick
  typedef struct packed {
    logic load;       // capture a new result this edge
    logic forceZero;  // loop is not tracking a reference
    logic bypass;     // fast-lock pass-through
  } psl_strobe_t;

endpackage

// File: rtl/psl_ctrl.sv
module psl_ctrl
  import psl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  input  logic        fastLock,
  input  logic [1:0]  opMode,
  output logic        inReady,
  output logic        outValid,
  output psl_strobe_t strb
);

  op_mode_e modeDec;
  logic     accept;
  logic     outValidQ;

  always_comb begin
    modeDec = op_mode_e'(opMode);
    inReady = !outValidQ || outReady;
    accept  = inValid && inReady;
    strb.load      = accept;
    strb.forceZero = (modeDec != MODE_NORMAL);
    strb.bypass    = (modeDec == MODE_NORMAL) && fastLock;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         outValidQ <= 1'b0;
    else if (accept)   outValidQ <= 1'b1;
    else if (outReady) outValidQ <= 1'b0;
  end

  assign outValid = outValidQ;

  // R7: an accepted word shows up on the next cycle
  p_latency_r7: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> outValid);

  // R7: a consumed word with no replacement leaves
  p_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !inValid) |=> !outValid);

  // R8: a stalled word stays valid
  p_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

endmodule

// File: rtl/psl_datapath.sv
module psl_datapath
  import psl_pkg::*;
#(
  parameter int ERR_W       = 16,
  parameter int SLOPE_LIMIT = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  psl_strobe_t             strb,
  input  logic signed [ERR_W-1:0] inErr,
  output logic signed [ERR_W-1:0] outErr
);

  localparam logic signed [ERR_W-1:0] POS_LIM = ERR_W'(SLOPE_LIMIT);
  localparam logic signed [ERR_W-1:0] NEG_LIM = -POS_LIM;

  logic signed [ERR_W-1:0] clampedErr;
  logic signed [ERR_W-1:0] nextErr;
  logic signed [ERR_W-1:0] errQ;

  always_comb begin
    if (inErr > POS_LIM)      clampedErr = POS_LIM;
    else if (inErr < NEG_LIM) clampedErr = NEG_LIM;
    else                      clampedErr = inErr;
  end

  always_comb begin
    if (strb.forceZero)   nextErr = '0;
    else if (strb.bypass) nextErr = inErr;
    else                  nextErr = clampedErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          errQ <= '0;
    else if (strb.load) errQ <= nextErr;
  end

  assign outErr = errQ;

  // R3 and R4: a limited tick lands inside the bound
  p_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.forceZero && !strb.bypass) |=>
      (outErr <= POS_LIM && outErr >= NEG_LIM));

  // R2: in-range errors are untouched
  p_inrange_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.forceZero && !strb.bypass &&
     inErr <= POS_LIM && inErr >= NEG_LIM) |=> (outErr == $past(inErr)));

  // R5: fast lock passes the error through
  p_bypass_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.bypass && !strb.forceZero) |=> (outErr == $past(inErr)));

  // R6: non-tracking modes give zero
  p_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.forceZero) |=> (outErr == '0));

  // R8: without a load the word holds
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(outErr));

endmodule

// File: rtl/phase_slope_limiter.sv
module phase_slope_limiter
  import psl_pkg::*;
#(
  parameter int ERR_W       = 16,
  parameter int SLOPE_LIMIT = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [ERR_W-1:0] inErr,
  input  logic             fastLock,
  input  logic [1:0]       opMode,
  output logic             outValid,
  input  logic             outReady,
  output logic [ERR_W-1:0] outErr
);

  psl_strobe_t             strb;
  logic signed [ERR_W-1:0] errS;

  psl_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .fastLock (fastLock),
    .opMode   (opMode),
    .inReady  (inReady),
    .outValid (outValid),
    .strb     (strb)
  );

  psl_datapath #(
    .ERR_W       (ERR_W),
    .SLOPE_LIMIT (SLOPE_LIMIT)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .inErr  ($signed(inErr)),
    .outErr (errS)
  );

  assign outErr = $unsigned(errS);

endmodule

// File: tb/phase_slope_limiter_bench.sv
module phase_slope_limiter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] inErr = '0;
  logic        fastLock = 1'b0;
  logic [1:0]  opMode = 2'b00;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [15:0] outErr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  phase_slope_limiter u_phase_slope_limiter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inErr(inErr), .fastLock(fastLock), .opMode(opMode),
    .outValid(outValid), .outReady(outReady), .outErr(outErr)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expect_err(input int e, input bit fl, input logic [1:0] m);
    if (m != 2'b00) return 0;
    if (fl) return e;
    if (e > 5) return 5;
    if (e < -5) return -5;
    return e;
  endfunction

  // one tick: accept, check result one edge later, check it leaves the next
  task automatic send(input int e, input bit fl, input logic [1:0] m, input string req);
    int exp;
    exp = expect_err(e, fl, m);
    @(negedge clk);
    inErr = 16'(e); fastLock = fl; opMode = m; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b1, "R7", int'(outValid), 1);
    check($signed(outErr) == exp, req, int'($signed(outErr)), exp);
    @(negedge clk);
    check(outValid == 1'b0, "R7", int'(outValid), 0);
  endtask

  task automatic t_reset;
    check(outValid == 1'b0, "R1", int'(outValid), 0);
    check(outErr == 16'd0, "R1", int'(outErr), 0);
    check(inReady == 1'b1, "R1", int'(inReady), 1);
  endtask

  task automatic t_inrange;
    send(0, 0, 2'b00, "R2");
    send(3, 0, 2'b00, "R2");
    send(5, 0, 2'b00, "R2");
    send(-5, 0, 2'b00, "R2");
    send(-1, 0, 2'b00, "R2");
  endtask

  task automatic t_positive;
    send(6, 0, 2'b00, "R3");
    send(1000, 0, 2'b00, "R3");
    send(32767, 0, 2'b00, "R3");
  endtask

  task automatic t_negative;
    send(-6, 0, 2'b00, "R4");
    send(-32768, 0, 2'b00, "R4");
  endtask

  task automatic t_fast;
    send(1000, 1, 2'b00, "R5");
    send(-300, 1, 2'b00, "R5");
    send(4, 1, 2'b00, "R5");
  endtask

  task automatic t_quiet;
    send(77, 0, 2'b01, "R6");
    send(-900, 1, 2'b10, "R6");
    send(3, 1, 2'b01, "R6");
    send(1234, 1, 2'b11, "R10");
  endtask

  task automatic t_nocarry;
    send(500, 0, 2'b00, "R9");
    send(2, 0, 2'b00, "R9");
    send(-700, 0, 2'b00, "R9");
    send(0, 0, 2'b00, "R9");
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    outReady = 1'b0;
    inErr = 16'(100); fastLock = 1'b0; opMode = 2'b00; inValid = 1'b1;
    @(negedge clk);
    inErr = 16'(-2);  // next word offered while stalled
    check(outValid == 1'b1, "R8", int'(outValid), 1);
    check($signed(outErr) == 5, "R8", int'($signed(outErr)), 5);
    check(inReady == 1'b0, "R8", int'(inReady), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(outValid == 1'b1, "R8", int'(outValid), 1);
      check($signed(outErr) == 5, "R8", int'($signed(outErr)), 5);
      check(inReady == 1'b0, "R8", int'(inReady), 0);
    end
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b1, "R8", int'(outValid), 1);
    check($signed(outErr) == -2, "R8", int'($signed(outErr)), -2);
    @(negedge clk);
    check(outValid == 1'b0, "R7", int'(outValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_inrange();
    t_positive();
    t_negative();
    t_fast();
    t_quiet();
    t_nocarry();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule